// File: doc/BRIEF.md
# Reset Cause Status Flags

This block keeps the two read-only cause flags of a microcontroller status register, the "time-out" flag and the "power-down" flag, and turns them into a cause code. The code tells firmware why the core last left reset or sleep. Four events move the flags: a power-on reset pulse, a sleep-instruction strobe, a watchdog-clear instruction strobe and a watchdog timeout strobe. An external reset pulse leaves both flags as they were, so firmware can read them after the reset. A sleep-mode indicator tells the block whether a watchdog timeout or an external reset reached a sleeping core or a running one.

The same register also holds three bits that software can read and write. Two of them select the register page and one selects the control-register page (page 0 or page 1). The block assembles the full status byte. The carry, digit-carry and zero bits come from the ALU and pass straight through into the byte.

Every input is a one-cycle, active-high, synchronous pulse or level sampled on the rising clock edge. All state is registered, and the cause code and status byte are decoded from that state with no further delay.

Top module: `rcs_status_top`

## Requirements
- R1: A cycle with `por` high sets T=1 and P=1 and clears both page selects to 0 on that edge, so the cause reads 0 (power-up). `por` takes priority over every other input in that cycle.
- R2: A sleep strobe, when no watchdog-clear, watchdog timeout or external reset is present in the same cycle, gives T=1 and P=0 on the next edge.
- R3: A watchdog-clear strobe, when no watchdog timeout or external reset is present in the same cycle, gives T=1 and P=1. It wins over a sleep strobe in the same cycle.
- R4: A watchdog timeout clears T and leaves P unchanged. It takes priority over both instruction strobes in the same cycle.
- R5: The cause code is derived from {T,P} as follows: 00 gives 1 (watchdog wake from sleep), 01 gives 2 (watchdog timeout while running), 10 gives 3 (external reset wake from sleep) and 11 gives 0 (power-up).
- R6: An external reset while `asleep` is low makes the cause read 4 (indeterminate). This state holds until `por`, a watchdog timeout, a sleep or watchdog-clear strobe, or an external reset with `asleep` high clears it.
- R7: An external reset does not change T or P, and any sleep or watchdog-clear strobe in the same cycle is ignored.
- R8: The status byte has this layout: bits 2..0 are `alu_flags` (carry at bit 0, digit carry at bit 1, zero at bit 2), bit 3 is P, bit 4 is T, bit 5 is the control-page select and bits 7..6 are the register-page select.
- R9: A write with `sw_we` high loads bits 7..5 of `sw_wdata` into the page selects. Bits 4..0 of the write have no effect on T or P.
- R10: An external reset or `por` clears the page selects to 0 and wins over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset pulse, active high, synchronous |
| ext_rst | input | 1 | External reset pulse, active high |
| sleep_cmd | input | 1 | Sleep-instruction strobe |
| wdclr_cmd | input | 1 | Watchdog-clear instruction strobe |
| wdt_expire | input | 1 | Watchdog timeout strobe |
| asleep | input | 1 | Core is in sleep mode |
| sw_we | input | 1 | Software write to the status register |
| sw_wdata | input | 8 | Software write data |
| alu_flags | input | 3 | Zero, digit carry and carry from the ALU |
| flag_t | output | 1 | Time-out flag |
| flag_p | output | 1 | Power-down flag |
| cause | output | 3 | Encoded cause of the last reset or wake-up |
| reg_page | output | 2 | Register-page select |
| ctl_page | output | 1 | Control-page select |
| status_byte | output | 8 | Assembled status register |

## Verification
A watchdog timeout can arrive in the same cycle as a sleep or watchdog-clear strobe, and an external reset can coincide with an instruction strobe or a software write. The stimulus table drives these collisions directly, for example a timeout together with a sleep strobe, and a reset while running together with a sleep strobe. Each collision is judged by the T, P and cause values on the next edge: the winning event must show, and the losing one must leave no trace. Separate directed cases pit a page write against an external reset and against `por`.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [2:0] {
    CAUSE_POWERUP   = 3'd0,
    CAUSE_WDT_SLEEP = 3'd1,
    CAUSE_WDT_RUN   = 3'd2,
    CAUSE_EXT_SLEEP = 3'd3,
    CAUSE_INDET     = 3'd4
  } cause_e;

  // Map the flag pair (and the indeterminate marker) to a cause code.
  function automatic cause_e decode_cause(input logic t, input logic p,
                                          input logic indet);
    if (indet) return CAUSE_INDET;
    case ({t, p})
      2'b00:   return CAUSE_WDT_SLEEP;
      2'b01:   return CAUSE_WDT_RUN;
      2'b10:   return CAUSE_EXT_SLEEP;
      default: return CAUSE_POWERUP;
    endcase
  endfunction

endpackage

// File: rtl/rcs_flag_ctrl.sv
module rcs_flag_ctrl (
  input  logic clk,
  input  logic por,
  input  logic ext_rst,
  input  logic sleep_cmd,
  input  logic wdclr_cmd,
  input  logic wdt_expire,
  input  logic asleep,
  output logic t_q,
  output logic p_q,
  output logic indet_q
);

  // Qualified events, after priority resolution.
  logic ev_wdt, ev_clr, ev_slp, ev_ext_run, ev_ext_slp;

  assign ev_wdt     = wdt_expire & ~por;
  assign ev_clr     = wdclr_cmd & ~wdt_expire & ~ext_rst & ~por;
  assign ev_slp     = sleep_cmd & ~wdclr_cmd & ~wdt_expire & ~ext_rst & ~por;
  assign ev_ext_run = ext_rst & ~asleep & ~por;
  assign ev_ext_slp = ext_rst & asleep & ~por;

  always_ff @(posedge clk) begin
    if (por) begin
      t_q     <= 1'b1;
      p_q     <= 1'b1;
      indet_q <= 1'b0;
    end else begin
      if (ev_wdt) begin
        t_q <= 1'b0;
      end else if (ev_clr) begin
        t_q <= 1'b1;
        p_q <= 1'b1;
      end else if (ev_slp) begin
        t_q <= 1'b1;
        p_q <= 1'b0;
      end
      if (ev_ext_run)
        indet_q <= 1'b1;
      else if (ev_ext_slp || ev_wdt || ev_clr || ev_slp)
        indet_q <= 1'b0;
    end
  end

  a_r1_por_sets_flags: assert property (@(posedge clk)
    por |=> (t_q && p_q && !indet_q));

  a_r2_sleep_result: assert property (@(posedge clk) disable iff (por)
    (sleep_cmd && !wdclr_cmd && !wdt_expire && !ext_rst) |=> (t_q && !p_q));

  a_r3_wdclr_result: assert property (@(posedge clk) disable iff (por)
    (wdclr_cmd && !wdt_expire && !ext_rst) |=> (t_q && p_q));

  a_r4_wdt_clears_t: assert property (@(posedge clk) disable iff (por)
    wdt_expire |=> !t_q);

  a_r4_wdt_keeps_p: assert property (@(posedge clk) disable iff (por)
    wdt_expire |=> $stable(p_q));

  a_r7_ext_holds_flags: assert property (@(posedge clk) disable iff (por)
    (ext_rst && !wdt_expire) |=> ($stable(t_q) && $stable(p_q)));

  a_r6_ext_run_indet: assert property (@(posedge clk) disable iff (por)
    (ext_rst && !asleep) |=> indet_q);

endmodule

// File: rtl/rcs_page_reg.sv
module rcs_page_reg #(
  parameter int RPAGE_W = 2
) (
  input  logic               clk,
  input  logic               por,
  input  logic               ext_rst,
  input  logic               we,
  input  logic [RPAGE_W:0]   wdata,
  output logic [RPAGE_W-1:0] rpage,
  output logic               cpage
);

  logic clr_ev;
  assign clr_ev = por | ext_rst;

  always_ff @(posedge clk) begin
    if (clr_ev) begin
      rpage <= '0;
      cpage <= 1'b0;
    end else if (we) begin
      rpage <= wdata[RPAGE_W:1];
      cpage <= wdata[0];
    end
  end

  a_r10_reset_clears_pages: assert property (@(posedge clk)
    (por || ext_rst) |=> (rpage == '0 && !cpage));

  a_r9_pages_hold_idle: assert property (@(posedge clk) disable iff (por)
    (!we && !ext_rst) |=> ($stable(rpage) && $stable(cpage)));

endmodule

// File: rtl/rcs_status_top.sv
module rcs_status_top #(
  parameter int RPAGE_W = 2,
  parameter int ALU_W   = 3
) (
  input  logic                     clk,
  input  logic                     por,
  input  logic                     ext_rst,
  input  logic                     sleep_cmd,
  input  logic                     wdclr_cmd,
  input  logic                     wdt_expire,
  input  logic                     asleep,
  input  logic                     sw_we,
  input  logic [ALU_W+RPAGE_W+2:0] sw_wdata,
  input  logic [ALU_W-1:0]         alu_flags,
  output logic                     flag_t,
  output logic                     flag_p,
  output logic [2:0]               cause,
  output logic [RPAGE_W-1:0]       reg_page,
  output logic                     ctl_page,
  output logic [ALU_W+RPAGE_W+2:0] status_byte
);
  import rcs_pkg::*;

  localparam int STAT_W  = ALU_W + RPAGE_W + 3;
  localparam int P_BIT   = ALU_W;
  localparam int T_BIT   = ALU_W + 1;
  localparam int CPG_BIT = ALU_W + 2;

  logic t_q, p_q, indet_q;
  cause_e cause_w;

  rcs_flag_ctrl u_flags (
    .clk        (clk),
    .por        (por),
    .ext_rst    (ext_rst),
    .sleep_cmd  (sleep_cmd),
    .wdclr_cmd  (wdclr_cmd),
    .wdt_expire (wdt_expire),
    .asleep     (asleep),
    .t_q        (t_q),
    .p_q        (p_q),
    .indet_q    (indet_q)
  );

  rcs_page_reg #(.RPAGE_W(RPAGE_W)) u_pages (
    .clk     (clk),
    .por     (por),
    .ext_rst (ext_rst),
    .we      (sw_we),
    .wdata   (sw_wdata[STAT_W-1:CPG_BIT]),
    .rpage   (reg_page),
    .cpage   (ctl_page)
  );

  assign cause_w = decode_cause(t_q, p_q, indet_q);
  assign cause   = cause_w;
  assign flag_t  = t_q;
  assign flag_p  = p_q;

  always_comb begin
    status_byte                       = '0;
    status_byte[ALU_W-1:0]            = alu_flags;
    status_byte[P_BIT]                = p_q;
    status_byte[T_BIT]                = t_q;
    status_byte[CPG_BIT]              = ctl_page;
    status_byte[STAT_W-1:CPG_BIT+1]   = reg_page;
  end

  a_r9_write_spares_flags: assert property (@(posedge clk) disable iff (por)
    (sw_we && !sleep_cmd && !wdclr_cmd && !wdt_expire)
      |=> ($stable(flag_t) && $stable(flag_p)));

endmodule

// File: tb/tb_rcs_status_top.sv
module tb_rcs_status_top;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       ext_rst = 1'b0, sleep_cmd = 1'b0, wdclr_cmd = 1'b0;
  logic       wdt_expire = 1'b0, asleep = 1'b0, sw_we = 1'b0;
  logic [7:0] sw_wdata = 8'h00;
  logic [2:0] alu_flags = 3'b000;
  logic       flag_t, flag_p, ctl_page;
  logic [2:0] cause;
  logic [1:0] reg_page;
  logic [7:0] status_byte;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rcs_status_top dut (
    .clk(clk), .por(por), .ext_rst(ext_rst), .sleep_cmd(sleep_cmd),
    .wdclr_cmd(wdclr_cmd), .wdt_expire(wdt_expire), .asleep(asleep),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .alu_flags(alu_flags),
    .flag_t(flag_t), .flag_p(flag_p), .cause(cause), .reg_page(reg_page),
    .ctl_page(ctl_page), .status_byte(status_byte)
  );

  // {por, ext_rst, sleep, wdclr, wdt, asleep} , {T, P, cause[2:0]}
  localparam int NV = 17;
  localparam logic [10:0] VEC [NV] = '{
    {6'b100000, 5'b11_000},  // R1 power-up
    {6'b000000, 5'b11_000},  // R5 idle, code 0
    {6'b001000, 5'b10_011},  // R2 sleep
    {6'b000011, 5'b00_001},  // R4 wdt in sleep
    {6'b000100, 5'b11_000},  // R3 wdclr
    {6'b000010, 5'b01_010},  // R4 wdt running
    {6'b001000, 5'b10_011},  // R2 sleep
    {6'b010001, 5'b10_011},  // R7 ext reset from sleep
    {6'b010000, 5'b10_100},  // R6 ext reset running
    {6'b000000, 5'b10_100},  // R6 indeterminate holds
    {6'b000100, 5'b11_000},  // R6 wdclr clears indet
    {6'b001010, 5'b01_010},  // R4 wdt beats sleep
    {6'b001100, 5'b11_000},  // R3 wdclr beats sleep
    {6'b001000, 5'b10_011},  // R2 sleep
    {6'b101010, 5'b11_000},  // R1 por beats wdt and sleep
    {6'b011000, 5'b11_100},  // R7 sleep ignored during ext reset
    {6'b000010, 5'b01_010}   // R6 wdt clears indet
  };

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    por = 0; ext_rst = 0; sleep_cmd = 0; wdclr_cmd = 0;
    wdt_expire = 0; asleep = 0; sw_we = 0; sw_wdata = 8'h00;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset state", {flag_t, flag_p, reg_page, ctl_page, cause}, 8'b11_00_0_000);

    for (int i = 0; i < NV; i++) begin
      {por, ext_rst, sleep_cmd, wdclr_cmd, wdt_expire, asleep} = VEC[i][10:5];
      @(negedge clk);
      check($sformatf("R1-R7 vector %0d", i), {3'b000, flag_t, flag_p, cause},
            {3'b000, VEC[i][4:0]});
      idle_inputs();
    end

    // R9: write page bits; bits 4..0 must not touch T/P (now T=0,P=1)
    sw_we = 1; sw_wdata = 8'b101_00000;
    @(negedge clk);
    idle_inputs();
    check("R9 page write", {5'b0, reg_page, ctl_page}, 8'b0000_0101);
    check("R9 flags untouched", {6'b0, flag_t, flag_p}, 8'b0000_0001);

    // R8 byte layout
    alu_flags = 3'b101;
    #0;
    check("R8 status byte", status_byte, 8'b10_1_0_1_101);

    sw_we = 1; sw_wdata = 8'b011_11111;
    @(negedge clk);
    idle_inputs();
    check("R9 second write", status_byte, 8'b01_1_0_1_101);

    // R10: ext reset beats write
    ext_rst = 1; asleep = 1; sw_we = 1; sw_wdata = 8'hE0;
    @(negedge clk);
    idle_inputs();
    check("R10 ext reset clears pages", status_byte, 8'b00_0_0_1_101);

    // R10: por beats write
    sw_we = 1; sw_wdata = 8'hE0;
    @(negedge clk);
    idle_inputs();
    sw_we = 1; sw_wdata = 8'hC0; por = 1;
    @(negedge clk);
    idle_inputs();
    check("R10 por clears pages", status_byte, 8'b00_0_1_1_101);
    check("R1 por cause", {5'b0, cause}, 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule